// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block paces the serial clock of an I2C master engine. It divides the system clock in two stages. The first stage counts M+1 system clocks. The second stage counts 2^(N+1) of those first-stage completions and then emits a one-cycle sample tick. A phase counter takes ten sample ticks to make one SCL period. During the first five ticks the SCL phase is low, and during the last five it is high. The resulting SCL frequency is f_clk / (10·(M+1)·2^(N+1)).

The rate is held in a 7-bit baud register. A write loads this register, and the soft reset input returns it to its default. Both actions also clear every divider and phase counter, so the new rate always starts from the beginning of a low phase. The master engine uses `tick` to sample and drive the bus, and it uses `scl_hi` as the level it should release or hold on SCL.

Top module: `i2c_scl_divider`

## Requirements
- R1: After reset, `baud_q` reads 0x44, which is M=8 in bits 6:3 and N=4 in bits 2:0. Both `tick` and `scl_hi` are low, and the first tick arrives in clock cycle 288 after reset is released.
- R2: A write (`baud_we` high) with `soft_rst` low loads `baud_wdata` into `baud_q` at the next clock edge. Bits 6:3 are the M field (0..15) and bits 2:0 are the N field (0..7).
- R3: In steady state, `tick` is high for exactly one cycle in every D = (M+1)·2^(N+1) cycles.
- R4: A write clears both divider stages and the phase counter. The first tick after a write is high in exactly clock cycle D after the edge that captured the write, and no earlier tick occurs. A second write in the middle of a count restarts the count.
- R5: `scl_hi` is low for five ticks and high for five ticks, so one SCL period is 10·D cycles. After a restart, `scl_hi` first rises in cycle 5·D+1 and first falls in cycle 10·D+1. It changes only in the cycle after a tick.
- R6: A pulse on `soft_rst` returns `baud_q` to 0x44 and restarts the counters. When `soft_rst` and `baud_we` are high in the same cycle, `soft_rst` wins.
- R7: While `baud_we` and `soft_rst` are both low, `baud_q` keeps its value whatever is on `baud_wdata`, and the tick spacing does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restore of the default rate, with a counter restart |
| baud_we | input | 1 | Baud register write strobe |
| baud_wdata | input | 7 | New baud value, M in bits 6:3 and N in bits 2:0 |
| baud_q | output | 7 | Current baud register value |
| tick | output | 1 | One-cycle sample tick, at ten times the SCL rate |
| scl_hi | output | 1 | SCL phase: 0 for low, 1 for high |

## Verification
The divider is tested at several settings:
- M=0, N=0 is the shortest case.
- M=15, N=0 exercises only the linear stage.
- M=0, N=7 exercises only the power-of-two stage.
- Mixed settings such as M=3, N=2 and M=5, N=1 exercise both stages together.
- The reset default is also tested.

Because these settings separate the two stages, a swapped field, an off-by-one limit, or a mask that covers one bit too many or too few each produce a different tick spacing. The test measures the first tick after a restart separately from the spacing between later ticks, so a counter that is not cleared on a write shows up even when the steady rate is correct. The SCL edges are timed at five and ten ticks so that a wrong split point or phase wrap is caught. Soft reset is tested on its own and together with a write in the same cycle.

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider #(
  parameter int M_W = 4,
  parameter int N_W = 3,
  parameter int PHASES = 10,
  parameter logic [M_W+N_W-1:0] RESET_BAUD = 'h44
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 baud_we,
  input  logic [M_W+N_W-1:0]   baud_wdata,
  output logic [M_W+N_W-1:0]   baud_q,
  output logic                 tick,
  output logic                 scl_hi
);
  localparam int BAUD_W = M_W + N_W;
  localparam int S2_W   = 1 << N_W;
  localparam int PH_W   = $clog2(PHASES);
  localparam int HALF   = PHASES / 2;

  logic [M_W-1:0]  m_f;
  logic [N_W-1:0]  n_f;
  logic [M_W-1:0]  lin_cnt;
  logic [S2_W-1:0] pow_cnt;
  logic [S2_W-1:0] pow_mask;
  logic [PH_W-1:0] phase;
  logic            restart, lin_done, pow_last;

  assign m_f      = baud_q[BAUD_W-1:N_W];
  assign n_f      = baud_q[N_W-1:0];
  assign restart  = baud_we | soft_rst;
  assign lin_done = (lin_cnt == m_f);
  assign pow_last = lin_done && (pow_cnt == pow_mask);
  assign scl_hi   = (phase >= PH_W'(HALF));

  always_comb begin
    for (int i = 0; i < S2_W; i++)
      pow_mask[i] = (i <= int'(n_f));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      baud_q <= RESET_BAUD;
    else if (soft_rst)
      baud_q <= RESET_BAUD;
    else if (baud_we)
      baud_q <= baud_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_cnt <= '0;
      pow_cnt <= '0;
      phase   <= '0;
      tick    <= 1'b0;
    end else if (restart) begin
      lin_cnt <= '0;
      pow_cnt <= '0;
      phase   <= '0;
      tick    <= 1'b0;
    end else begin
      tick    <= pow_last;
      lin_cnt <= lin_done ? '0 : lin_cnt + 1'b1;
      if (lin_done)
        pow_cnt <= pow_last ? '0 : pow_cnt + 1'b1;
      if (tick)
        phase <= (phase == PH_W'(PHASES - 1)) ? '0 : phase + 1'b1;
    end
  end

  // R1
  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(PHASES));

  // R2
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_we && !soft_rst) |=> baud_q == $past(baud_wdata));

  // R3
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R4
  a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!tick && !scl_hi));

  // R5
  a_r5_scl_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(scl_hi));

  // R6
  a_r6_soft_default: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> baud_q == RESET_BAUD);

  // R7
  a_r7_baud_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_we && !soft_rst) |=> $stable(baud_q));
endmodule

// File: tb/i2c_scl_divider_test.sv
module i2c_scl_divider_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic baud_we = 1'b0;
  logic [6:0] baud_wdata = '0;
  logic [6:0] baud_q;
  logic tick, scl_hi;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  i2c_scl_divider uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_we(baud_we),
    .baud_wdata(baud_wdata), .baud_q(baud_q), .tick(tick), .scl_hi(scl_hi)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int span(int m, int n);
    return (m + 1) * (1 << (n + 1));
  endfunction

  task automatic write_baud(int m, int n);
    @(negedge clk);
    baud_wdata = 7'((m << 3) | n);
    baud_we = 1'b1;
    @(negedge clk);
    baud_we = 1'b0;
  endtask

  task automatic count_to_tick(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!tick && cnt < 50000);
  endtask

  task automatic t_reset();
    int c;
    check("R1 baud default", int'(baud_q), 'h44);
    check("R1 tick low", int'(tick), 0);
    check("R1 scl low", int'(scl_hi), 0);
    count_to_tick(c);
    check("R1 first tick", c, 288);
  endtask

  task automatic t_rate(int m, int n);
    int c;
    write_baud(m, n);
    check("R2 baud load", int'(baud_q), (m << 3) | n);
    count_to_tick(c);
    check("R4 first tick after write", c, span(m, n));
    @(negedge clk);
    check("R3 tick one cycle", int'(tick), 0);
    count_to_tick(c);
    check("R3 tick spacing", c + 1, span(m, n));
  endtask

  task automatic t_scl(int m, int n);
    int c, rise, fall;
    bit seen;
    write_baud(m, n);
    rise = -1; fall = -1; seen = 0;
    for (int i = 1; i <= 10 * span(m, n) + 2; i++) begin
      @(negedge clk);
      if (scl_hi && !seen) begin rise = i; seen = 1; end
      else if (!scl_hi && seen && fall < 0) fall = i;
    end
    check("R5 scl rise", rise, 5 * span(m, n) + 1);
    check("R5 scl fall", fall, 10 * span(m, n) + 1);
    c = 0;
  endtask

  task automatic t_midwrite();
    int c;
    write_baud(1, 1);
    repeat (5) @(negedge clk);
    write_baud(1, 1);
    count_to_tick(c);
    check("R4 restart mid count", c, 8);
  endtask

  task automatic t_soft();
    int c;
    write_baud(0, 0);
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check("R6 soft default", int'(baud_q), 'h44);
    count_to_tick(c);
    check("R6 soft restart tick", c, 288);
    @(negedge clk);
    baud_wdata = 7'h01;
    baud_we = 1'b1;
    soft_rst = 1'b1;
    @(negedge clk);
    baud_we = 1'b0;
    soft_rst = 1'b0;
    check("R6 soft beats write", int'(baud_q), 'h44);
  endtask

  task automatic t_hold();
    int c;
    write_baud(2, 0);
    baud_wdata = 7'h7F;
    count_to_tick(c);
    count_to_tick(c);
    check("R7 baud holds", int'(baud_q), (2 << 3));
    check("R7 spacing holds", c, span(2, 0));
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rate(0, 0);
    t_rate(15, 0);
    t_rate(0, 7);
    t_rate(3, 2);
    t_rate(5, 1);
    t_scl(0, 0);
    t_scl(2, 1);
    t_midwrite();
    t_soft();
    t_hold();
    finish_run();
  end
endmodule